// File: doc/BRIEF.md
# Packetised DRAM Command Receiver

This block sits at the command input of a packet-addressed DRAM device. Commands reach it on a narrow bus: ten command bits plus a start line. A packet is four consecutive clock cycles (beats) on that bus, 40 bits in all, and the most significant bits come first. The start line is high only during the first beat. The receiver builds the 40-bit packet and checks the 8-bit device identifier it carries against the identifier on `ownId`. It then decodes the command into a single operation code with its address fields.

Packets for other devices, packets that use reserved command bits and packets with an unknown maintenance code are dropped without any output. An accepted packet raises `pktValid` for one cycle and presents the operation, bank, row, spare and column values. These values stay on the outputs until the next accepted packet. The start line is always obeyed: a packet in progress is abandoned when the start line rises again, and the current word becomes the first beat of a new packet.

Top module: `pktrx_top`

## Requirements
- R1: After reset, `pktValid` is low and `opCode`, `bankOut`, `rowOut`, `spareOut` and `colOut` are all zero.
- R2: A packet is four beats on consecutive clocks. `cmdFlag` is high on the first beat and low on the other three. Beat 0 supplies packet bits 39:30 and beat 3 supplies bits 9:0. `pktValid` is high for exactly the one cycle after the clock edge that samples beat 3.
- R3: Packet bits 39:32 are compared with `ownId` when beat 3 is sampled. On a mismatch there is no strobe, and every field output keeps its previous value.
- R4: `cmdFlag` high during beat 1, 2 or 3 of a packet abandons that packet. The current word becomes beat 0 of a new packet.
- R5: Words with `cmdFlag` low while no packet is in progress are ignored: they cause no strobe and no change of outputs.
- R6: With packet bit 31 clear, the packet is a data access. Bit 26 clear gives `opCode` 0 (read) and bit 26 set gives `opCode` 1 (write). Bits 28:27 are ignored.
- R7: With packet bit 31 set, the packet is a maintenance command selected by bits 28:26: 0 is row open (`opCode` 2), 1 is row close (3), 2 is refresh (4), 3 is configuration read (5) and 4 is configuration write (6). Codes 5 to 7 are dropped with no strobe.
- R8: Packet bits 30:29 are reserved. If either bit is set, the packet is dropped.
- R9: On an accepted packet, the outputs are `bankOut` = bits 25:23, `rowOut` = bits 22:12, `spareOut` = bits 11:7 and `colOut` = bits 6:0. All field outputs hold their values until the next accepted packet.
- R10: A new packet can start on the cycle right after beat 3 of the previous one, with no idle gap, and both packets are decoded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one beat per rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| cmdFlag | input | 1 | Start line, high on the first beat of a packet |
| cmdWord | input | 10 | Command bits of the current beat |
| ownId | input | 8 | Identifier this device answers to |
| pktValid | output | 1 | One-cycle strobe for an accepted packet |
| opCode | output | 3 | Decoded operation (0 to 6) |
| bankOut | output | 3 | Bank field |
| rowOut | output | 11 | Row field |
| spareOut | output | 5 | Spare expansion field |
| colOut | output | 7 | Column field |

## Verification
A beat counter that is off by one has visible effects at the ports. The strobe comes one cycle early or late, or it is missing when packets arrive back to back. The decoded fields also come out shifted by a whole beat, and all of this shows on the very first packet. A shift register that does not clear, or restarts badly, after a start line in mid-packet puts stale bits into the identifier field. That makes a valid packet vanish on the next strobe. Sweeping all 64 command codes, against both a matching and a mismatching identifier, shows any decode slip at the first code it affects.

// File: rtl/pktrx_pkg.sv
package pktrx_pkg;

  localparam int CMD_W  = 10;
  localparam int BEATS  = 4;
  localparam int ID_W   = 8;
  localparam int PKT_W  = CMD_W * BEATS;

  // field positions inside the assembled packet
  localparam int ID_LO    = 32;
  localparam int CMD_LO   = 26;
  localparam int BANK_LO  = 23;
  localparam int ROW_LO   = 12;
  localparam int SPARE_LO = 7;
  localparam int COL_LO   = 0;

  localparam int BANK_W  = CMD_LO - BANK_LO;
  localparam int ROW_W   = BANK_LO - ROW_LO;
  localparam int SPARE_W = ROW_LO - SPARE_LO;
  localparam int COL_W   = SPARE_LO - COL_LO;
  localparam int OPC_W   = 6;

  typedef enum logic [2:0] {
    OP_READ      = 3'd0,
    OP_WRITE     = 3'd1,
    OP_ROW_OPEN  = 3'd2,
    OP_ROW_CLOSE = 3'd3,
    OP_REFRESH   = 3'd4,
    OP_CFG_READ  = 3'd5,
    OP_CFG_WRITE = 3'd6
  } op_e;

  typedef struct packed {
    logic loadFirst;  // start a new packet with this word
    logic shiftIn;    // append a middle beat
    logic commit;     // this word is the last beat
  } rx_strobe_t;

endpackage

// File: rtl/pktrx_ctrl.sv
module pktrx_ctrl
  import pktrx_pkg::*;
#(
  parameter int BEATS_P = BEATS
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       cmdFlag,
  output rx_strobe_t strobe
);

  localparam int BEAT_W = (BEATS_P > 2) ? $clog2(BEATS_P) : 1;
  localparam logic [BEAT_W-1:0] LAST_BEAT = BEAT_W'(BEATS_P - 1);

  logic              busy;
  logic [BEAT_W-1:0] beatIdx;

  always_comb begin
    strobe           = '0;
    strobe.loadFirst = cmdFlag;
    strobe.shiftIn   = !cmdFlag && busy && (beatIdx != LAST_BEAT);
    strobe.commit    = !cmdFlag && busy && (beatIdx == LAST_BEAT);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy    <= 1'b0;
      beatIdx <= '0;
    end else if (cmdFlag) begin
      busy    <= 1'b1;
      beatIdx <= BEAT_W'(1);
    end else if (busy) begin
      if (beatIdx == LAST_BEAT) begin
        busy    <= 1'b0;
        beatIdx <= '0;
      end else begin
        beatIdx <= beatIdx + BEAT_W'(1);
      end
    end
  end

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strobe)) else $error("strobes overlap"); // R2

  AST_FLAG_RESTART: assert property (@(posedge clk) disable iff (!rstN)
    cmdFlag |=> (busy && beatIdx == BEAT_W'(1))) else $error("flag did not restart"); // R4

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !cmdFlag) |-> !strobe.shiftIn && !strobe.commit) else $error("idle word used"); // R5

endmodule

// File: rtl/pktrx_dp.sv
module pktrx_dp
  import pktrx_pkg::*;
#(
  parameter int CMD_W_P = CMD_W,
  parameter int BEATS_P = BEATS,
  parameter int ID_W_P  = ID_W
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  rx_strobe_t           strobe,
  input  logic [CMD_W_P-1:0]   cmdWord,
  input  logic [ID_W_P-1:0]    ownId,
  output logic                 pktValid,
  output logic [2:0]           opCode,
  output logic [BANK_W-1:0]    bankOut,
  output logic [ROW_W-1:0]     rowOut,
  output logic [SPARE_W-1:0]   spareOut,
  output logic [COL_W-1:0]     colOut
);

  localparam int PKT_W_L = CMD_W_P * BEATS_P;
  localparam int HOLD_W  = PKT_W_L - CMD_W_P;

  logic [HOLD_W-1:0]  held;
  logic [PKT_W_L-1:0] full;
  logic [OPC_W-1:0]   cmd;
  logic               idHit;
  logic               legal;
  op_e                opNext;
  logic               accept;

  // earlier beats, oldest in the top bits
  always_ff @(posedge clk) begin
    if (!rstN) begin
      held <= '0;
    end else if (strobe.loadFirst) begin
      held <= {{(HOLD_W-CMD_W_P){1'b0}}, cmdWord};
    end else if (strobe.shiftIn) begin
      held <= {held[HOLD_W-CMD_W_P-1:0], cmdWord};
    end
  end

  assign full  = {held, cmdWord};
  assign cmd   = full[CMD_LO +: OPC_W];
  assign idHit = (full[ID_LO +: ID_W_P] == ownId);

  always_comb begin
    opNext = OP_READ;
    legal  = (cmd[4:3] == 2'b00);
    if (!cmd[5]) begin
      opNext = cmd[0] ? OP_WRITE : OP_READ;
    end else begin
      unique case (cmd[2:0])
        3'd0:    opNext = OP_ROW_OPEN;
        3'd1:    opNext = OP_ROW_CLOSE;
        3'd2:    opNext = OP_REFRESH;
        3'd3:    opNext = OP_CFG_READ;
        3'd4:    opNext = OP_CFG_WRITE;
        default: legal  = 1'b0;
      endcase
    end
  end

  assign accept = strobe.commit && idHit && legal;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pktValid <= 1'b0;
      opCode   <= '0;
      bankOut  <= '0;
      rowOut   <= '0;
      spareOut <= '0;
      colOut   <= '0;
    end else begin
      pktValid <= accept;
      if (accept) begin
        opCode   <= opNext;
        bankOut  <= full[BANK_LO +: BANK_W];
        rowOut   <= full[ROW_LO +: ROW_W];
        spareOut <= full[SPARE_LO +: SPARE_W];
        colOut   <= full[COL_LO +: COL_W];
      end
    end
  end

  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    pktValid |=> !pktValid) else $error("strobe longer than one cycle"); // R2

  AST_VALID_AFTER_LAST: assert property (@(posedge clk) disable iff (!rstN)
    pktValid |-> $past(strobe.commit)) else $error("strobe without last beat"); // R2

  AST_OP_LEGAL: assert property (@(posedge clk) disable iff (!rstN)
    pktValid |-> (opCode <= 3'd6)) else $error("undefined op code"); // R7

  AST_FIELDS_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !pktValid |-> ($stable(rowOut) && $stable(colOut) && $stable(bankOut))) else $error("fields moved"); // R9

endmodule

// File: rtl/pktrx_top.sv
module pktrx_top (
  input  logic        clk,
  input  logic        rstN,
  input  logic        cmdFlag,
  input  logic [9:0]  cmdWord,
  input  logic [7:0]  ownId,
  output logic        pktValid,
  output logic [2:0]  opCode,
  output logic [2:0]  bankOut,
  output logic [10:0] rowOut,
  output logic [4:0]  spareOut,
  output logic [6:0]  colOut
);
  import pktrx_pkg::*;

  rx_strobe_t strobe;

  pktrx_ctrl #(.BEATS_P(BEATS)) uCtrl (
    .clk     (clk),
    .rstN    (rstN),
    .cmdFlag (cmdFlag),
    .strobe  (strobe)
  );

  pktrx_dp #(.CMD_W_P(CMD_W), .BEATS_P(BEATS), .ID_W_P(ID_W)) uDp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .cmdWord  (cmdWord),
    .ownId    (ownId),
    .pktValid (pktValid),
    .opCode   (opCode),
    .bankOut  (bankOut),
    .rowOut   (rowOut),
    .spareOut (spareOut),
    .colOut   (colOut)
  );

endmodule

// File: tb/pktrx_top_test.sv
`timescale 1ns/1ps
module pktrx_top_test;

  logic        clk = 1'b0;
  logic        rstN;
  logic        cmdFlag;
  logic [9:0]  cmdWord;
  logic [7:0]  ownId;
  logic        pktValid;
  logic [2:0]  opCode;
  logic [2:0]  bankOut;
  logic [10:0] rowOut;
  logic [4:0]  spareOut;
  logic [6:0]  colOut;

  int testCount = 0;
  int failCount = 0;
  bit done = 1'b0;

  logic [39:0] lastOk;

  always #2.5 clk = ~clk;

  pktrx_top uut (
    .clk(clk), .rstN(rstN), .cmdFlag(cmdFlag), .cmdWord(cmdWord), .ownId(ownId),
    .pktValid(pktValid), .opCode(opCode), .bankOut(bankOut), .rowOut(rowOut),
    .spareOut(spareOut), .colOut(colOut)
  );

  task automatic check(input string req, input int got, input int exp);
    testCount++;
    if (got != exp) begin
      failCount++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  function automatic logic [39:0] mk(input int id, input int cmd, input int bank,
                                     input int row, input int spare, input int col);
    return {8'(id), 6'(cmd), 3'(bank), 11'(row), 5'(spare), 7'(col)};
  endfunction

  // packet acceptance and op code from the command value
  function automatic bit expLegal(input int cmd);
    int c5 = cmd / 32;
    int rsv = (cmd / 8) % 4;
    return (rsv == 0) && (c5 == 0 || (cmd % 8) < 5);
  endfunction

  function automatic int expOp(input int cmd);
    return (cmd / 32 == 0) ? (cmd % 2) : 2 + (cmd % 8);
  endfunction

  // caller stands at a falling edge; returns at the falling edge after beat n-1
  task automatic drive(input logic [39:0] pkt, input int n);
    for (int b = 0; b < n; b++) begin
      cmdFlag = (b == 0);
      cmdWord = pkt[39 - 10*b -: 10];
      @(negedge clk);
    end
    cmdFlag = 1'b0;
    cmdWord = '0;
  endtask

  task automatic checkFields(input string req, input logic [39:0] p);
    check({req, " bank"},  bankOut,  int'(p[25:23]));
    check({req, " row"},   rowOut,   int'(p[22:12]));
    check({req, " spare"}, spareOut, int'(p[11:7]));
    check({req, " col"},   colOut,   int'(p[6:0]));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      testCount++;
      failCount++;
      $display("FAIL watchdog: got 0 expected 1");
      $display("[TB] %0d tests run, %0d failed", testCount, failCount);
      $finish;
    end
  end

  initial begin
    logic [39:0] p;
    rstN = 1'b0; cmdFlag = 1'b0; cmdWord = '0; ownId = 8'hA5;
    lastOk = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1 reset state
    check("R1 valid", pktValid, 0);
    check("R1 op", opCode, 0);
    checkFields("R1", 40'h0);

    // R6 R7 R8 sweep of every command code, matching identifier
    for (int c = 0; c < 64; c++) begin
      p = mk(8'hA5, c, c % 8, (c * 37 + 5) % 2048, c % 32, (c * 11) % 128);
      drive(p, 4);
      check("R2 R6 R7 R8 valid", pktValid, expLegal(c));
      if (expLegal(c)) begin
        check("R6 R7 op", opCode, expOp(c));
        lastOk = p;
      end
      checkFields("R9", lastOk);
      // R3 same packet, wrong identifier
      p = mk(8'hA5 ^ (1 << (c % 8)), 32 - (c % 2) * 31, c, c * 3, c, c);
      drive(p, 4);
      check("R3 mismatch valid", pktValid, 0);
      checkFields("R3 held", lastOk);
      cmdFlag = 1'b0;
      @(negedge clk);
    end

    // R2 strobe lasts one cycle, nothing during beats
    p = mk(8'hA5, 1, 5, 1234, 17, 99);
    drive(p, 3);
    check("R2 before last beat", pktValid, 0);
    cmdWord = p[9:0];
    @(negedge clk);
    check("R2 strobe", pktValid, 1);
    @(negedge clk);
    check("R2 single cycle", pktValid, 0);
    lastOk = p;

    // R4 abort after one, two and three beats
    for (int k = 1; k < 4; k++) begin
      drive(mk(8'hA5, 0, 7, 2047, 31, 127), k);
      p = mk(8'hA5, 34, k, 100 + k, k, 10 + k);
      drive(p, 4);
      check("R4 restart valid", pktValid, 1);
      check("R4 restart op", opCode, 4);
      checkFields("R4", p);
      lastOk = p;
      @(negedge clk);
    end

    // R5 unflagged words while idle
    for (int i = 0; i < 6; i++) begin
      cmdFlag = 1'b0;
      cmdWord = (i % 2) ? 10'h295 : 10'h3FF;
      @(negedge clk);
      check("R5 idle valid", pktValid, 0);
    end
    checkFields("R5 held", lastOk);

    // R10 back-to-back packets, several identifiers
    for (int j = 0; j < 8; j++) begin
      ownId = 8'(j * 29);
      p = mk(j * 29, 32 + j % 5, j, j * 200, j * 3, j * 15);
      drive(p, 4);
      check("R10 valid", pktValid, 1);
      check("R10 op", opCode, 2 + j % 5);
      checkFields("R10", p);
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end

endmodule